// File: doc/BRIEF.md
# Interrupt Source Controller

This block collects a fixed set of interrupt input lines and turns them into numbered interrupt offers for one presentation unit downstream. Each line is configured by a strap as either a level source, which is offered while its line is high, or a message source, which fires once on each rising edge of its line. Every source stores a destination server number and an 8-bit priority. The value 0xFF is the masked priority. An offer carries the global interrupt number of the source, which is its local index plus the parameter `BASE`, together with the stored priority and server.

The presentation unit returns three kinds of command. A reject hands an offer back. An end-of-interrupt closes one. A resend asks every source to try again. A reject makes a message source remember that it was refused, and it lets a level source be offered again. An end-of-interrupt only re-arms level sources. Offers that wait are served by a round-robin arbiter, and at most one offer leaves the block per cycle. A configuration write port sets the server and priority of one source at a time.

Top module: `irq_source_ctrl`

## Requirements
- R1: After reset every source is masked (priority 0xFF) and has all status cleared, so no offer is made until a source is configured. The level/message choice comes only from `src_level_i`, where 1 selects level.
- R2: A rising edge on the line of an unmasked message source produces an offer for that source, with its priority and server, on the second clock edge after the line is sampled high. A rising edge on a masked message source makes no offer and records a masked-pending flag.
- R3: A level source makes one offer when its line goes high while it is unmasked and not already sent, and it then counts as sent. While it is sent it makes no further offers, even if its line stays high.
- R4: A reject that names a message source marks it as rejected. A reject that names a level source clears its sent state. Neither makes an offer on its own.
- R5: A resend makes every rejected message source clear that mark and offer again if it is unmasked. It also makes every level source that is unmasked, high and not sent offer again.
- R6: An end-of-interrupt clears the sent state of a level source without making an offer. It has no effect on a message source.
- R7: A configuration write stores the server and priority. If a message source has masked-pending set and the new priority is not 0xFF, the write clears the flag and makes an offer. A write to a level source re-evaluates it as in R3. A write to a message source that is not masked-pending makes no offer.
- R8: A reject or end-of-interrupt number outside BASE to BASE+N-1 changes no source, even when its low bits match a valid index.
- R9: At most one offer is made per cycle. Sources that request at the same time are served one after another in later cycles. Each offer is valid for a single cycle and never carries priority 0xFF.
- R10: A reject and a line change for the same level source in the same cycle are applied with the reject first, so the line change can produce a new offer.
- R11: The offered number is always BASE plus the local index of the source, and it lies in BASE to BASE+N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_level_i | input | N | Per-source type strap, 1 = level, 0 = message |
| irq_line_i | input | N | Interrupt input lines |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Local index of the source being written |
| cfg_server_i | input | SRV_W | Server number to store |
| cfg_prio_i | input | 8 | Priority to store (0xFF masks the source) |
| rej_valid_i | input | 1 | Reject command valid |
| rej_num_i | input | GNUM_W | Global number being rejected |
| eoi_valid_i | input | 1 | End-of-interrupt command valid |
| eoi_num_i | input | GNUM_W | Global number being completed |
| resend_i | input | 1 | Resend request for all sources |
| offer_valid_o | output | 1 | Offer valid for one cycle |
| offer_num_o | output | GNUM_W | Global number offered |
| offer_prio_o | output | 8 | Priority of the offer |
| offer_server_o | output | SRV_W | Destination server of the offer |

## Verification
Corrupted status bits in a source show up at the offer port within two cycles of the next stimulus that reads them. A lost sent or rejected bit shows as a missing or duplicate offer after a resend. A wrong masked-pending bit shows as a missing offer after a configuration write. Errors in number decoding show as an offer after a resend that should have made none, because an out-of-range reject that aliases onto a real source changes what that source does next. Arbitration faults show as two sources offered in one cycle, a requester that is never served, or an offer carrying the masked priority.

// File: rtl/isc_pkg.sv
`timescale 1ns/1ps
package isc_pkg;
  localparam int PRIO_W = 8;
  typedef logic [PRIO_W-1:0] prio_t;
  localparam prio_t PRIO_MASKED = 8'hFF;

  // per-source status flags
  typedef struct packed {
    logic line_q;   // last sampled line (asserted / edge reference)
    logic sent;     // level: offer outstanding
    logic mpend;    // message: triggered while masked
    logic rejd;     // message: offer was rejected
    logic req;      // waiting in arbiter
  } slot_st_t;
endpackage

// File: rtl/isc_num_dec.sv
`timescale 1ns/1ps
module isc_num_dec #(
  parameter int N      = 16,
  parameter int GNUM_W = 16,
  parameter int BASE   = 4096
) (
  input  logic              valid_i,
  input  logic [GNUM_W-1:0] num_i,
  output logic [N-1:0]      hit_o
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [GNUM_W:0] BASE_EXT = (GNUM_W+1)'(BASE);
  localparam logic [GNUM_W:0] CNT_EXT  = (GNUM_W+1)'(N);
  localparam logic [N-1:0]    ONE      = {{(N-1){1'b0}}, 1'b1};

  logic [GNUM_W:0] diff;
  logic            in_range;

  // R8: numbers outside BASE..BASE+N-1 select nothing
  always_comb begin
    diff     = {1'b0, num_i} - BASE_EXT;
    in_range = !diff[GNUM_W] && (diff < CNT_EXT);
    hit_o    = (valid_i && in_range) ? (ONE << diff[IDX_W-1:0]) : '0;
  end
endmodule

// File: rtl/isc_src_slot.sv
`timescale 1ns/1ps
module isc_src_slot
  import isc_pkg::*;
#(
  parameter int SRV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_level_i,
  input  logic             line_i,
  input  logic             gnt_i,
  input  logic             rej_hit_i,
  input  logic             eoi_hit_i,
  input  logic             cfg_hit_i,
  input  logic [SRV_W-1:0] cfg_server_i,
  input  prio_t            cfg_prio_i,
  input  logic             resend_i,
  output logic             req_o,
  output prio_t            prio_o,
  output logic [SRV_W-1:0] server_o
);
  slot_st_t         st_q, st_d;
  prio_t            prio_q, prio_d;
  logic [SRV_W-1:0] srv_q, srv_d;
  logic             eval;

  always_comb begin
    st_d   = st_q;
    prio_d = prio_q;
    srv_d  = srv_q;
    eval   = 1'b0;

    if (gnt_i) st_d.req = 1'b0;

    // R10: returned commands are applied before line and write effects
    // R4
    if (rej_hit_i) begin
      if (is_level_i) st_d.sent = 1'b0;
      else            st_d.rejd = 1'b1;
    end
    // R6
    if (eoi_hit_i && is_level_i) st_d.sent = 1'b0;

    st_d.line_q = line_i;
    if (is_level_i) begin
      // R3: a change of the line triggers re-evaluation
      if (line_i != st_q.line_q) eval = 1'b1;
    end else if (line_i && !st_q.line_q) begin
      // R2
      if (prio_q == PRIO_MASKED) st_d.mpend = 1'b1;
      else                       st_d.req   = 1'b1;
    end

    // R7
    if (cfg_hit_i) begin
      prio_d = cfg_prio_i;
      srv_d  = cfg_server_i;
      if (is_level_i) begin
        eval = 1'b1;
      end else if (st_d.mpend && (cfg_prio_i != PRIO_MASKED)) begin
        st_d.mpend = 1'b0;
        st_d.req   = 1'b1;
      end
    end

    // R5
    if (resend_i) begin
      if (is_level_i) begin
        eval = 1'b1;
      end else if (st_d.rejd) begin
        st_d.rejd = 1'b0;
        if (prio_d != PRIO_MASKED) st_d.req = 1'b1;
      end
    end

    if (eval && (prio_d != PRIO_MASKED) && st_d.line_q && !st_d.sent) begin
      st_d.sent = 1'b1;
      st_d.req  = 1'b1;
    end
  end

  // R1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      prio_q <= PRIO_MASKED;
      srv_q  <= '0;
    end else begin
      st_q <= st_d;
      if (cfg_hit_i) begin
        prio_q <= prio_d;
        srv_q  <= srv_d;
      end
    end
  end

  // R9: a masked source never competes for the output
  assign req_o    = st_q.req && (prio_q != PRIO_MASKED);
  assign prio_o   = prio_q;
  assign server_o = srv_q;
endmodule

// File: rtl/isc_rr_arb.sv
`timescale 1ns/1ps
module isc_rr_arb #(
  parameter int N = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] gnt_idx_o,
  output logic             gnt_vld_o
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [IDX_W-1:0] last_q;

  // R9: search starts one past the last winner
  always_comb begin
    gnt_vld_o = 1'b0;
    gnt_idx_o = '0;
    for (int k = 1; k <= N; k++) begin
      int cand;
      cand = int'(last_q) + k;
      if (cand >= N) cand = cand - N;
      if (!gnt_vld_o && req_i[cand]) begin
        gnt_vld_o = 1'b1;
        gnt_idx_o = IDX_W'(cand);
      end
    end
    gnt_o = gnt_vld_o ? (ONE << gnt_idx_o) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         last_q <= IDX_W'(N-1);
    else if (gnt_vld_o) last_q <= gnt_idx_o;
  end
endmodule

// File: rtl/irq_source_ctrl.sv
`timescale 1ns/1ps
module irq_source_ctrl
  import isc_pkg::*;
#(
  parameter int N      = 16,
  parameter int GNUM_W = 16,
  parameter int BASE   = 4096,
  parameter int SRV_W  = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      src_level_i,
  input  logic [N-1:0]      irq_line_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [SRV_W-1:0]  cfg_server_i,
  input  logic [7:0]        cfg_prio_i,
  input  logic              rej_valid_i,
  input  logic [GNUM_W-1:0] rej_num_i,
  input  logic              eoi_valid_i,
  input  logic [GNUM_W-1:0] eoi_num_i,
  input  logic              resend_i,
  output logic              offer_valid_o,
  output logic [GNUM_W-1:0] offer_num_o,
  output logic [7:0]        offer_prio_o,
  output logic [SRV_W-1:0]  offer_server_o
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0]     rej_hit, eoi_hit, cfg_hit;
  logic [N-1:0]     req_vec, gnt_vec;
  logic [IDX_W-1:0] gnt_idx;
  logic             gnt_vld;
  prio_t            slot_prio [N];
  logic [SRV_W-1:0] slot_srv  [N];

  isc_num_dec #(.N(N), .GNUM_W(GNUM_W), .BASE(BASE)) u_rej_dec (
    .valid_i (rej_valid_i),
    .num_i   (rej_num_i),
    .hit_o   (rej_hit)
  );

  isc_num_dec #(.N(N), .GNUM_W(GNUM_W), .BASE(BASE)) u_eoi_dec (
    .valid_i (eoi_valid_i),
    .num_i   (eoi_num_i),
    .hit_o   (eoi_hit)
  );

  assign cfg_hit = cfg_we_i ? (ONE << cfg_idx_i) : '0;

  for (genvar g = 0; g < N; g++) begin : g_slot
    isc_src_slot #(.SRV_W(SRV_W)) u_slot (
      .clk          (clk),
      .rst_n        (rst_n),
      .is_level_i   (src_level_i[g]),
      .line_i       (irq_line_i[g]),
      .gnt_i        (gnt_vec[g]),
      .rej_hit_i    (rej_hit[g]),
      .eoi_hit_i    (eoi_hit[g]),
      .cfg_hit_i    (cfg_hit[g]),
      .cfg_server_i (cfg_server_i),
      .cfg_prio_i   (cfg_prio_i),
      .resend_i     (resend_i),
      .req_o        (req_vec[g]),
      .prio_o       (slot_prio[g]),
      .server_o     (slot_srv[g])
    );
  end

  isc_rr_arb #(.N(N)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_vec),
    .gnt_o     (gnt_vec),
    .gnt_idx_o (gnt_idx),
    .gnt_vld_o (gnt_vld)
  );

  // R11: offer register, number = BASE + local index
  logic              ofr_vld_d;
  logic [GNUM_W-1:0] ofr_num_d;
  prio_t             ofr_prio_d;
  logic [SRV_W-1:0]  ofr_srv_d;

  always_comb begin
    ofr_vld_d  = gnt_vld;
    ofr_num_d  = GNUM_W'(BASE) + GNUM_W'(gnt_idx);
    ofr_prio_d = slot_prio[gnt_idx];
    ofr_srv_d  = slot_srv[gnt_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offer_valid_o  <= 1'b0;
      offer_num_o    <= '0;
      offer_prio_o   <= PRIO_MASKED;
      offer_server_o <= '0;
    end else begin
      offer_valid_o <= ofr_vld_d;
      if (ofr_vld_d) begin
        offer_num_o    <= ofr_num_d;
        offer_prio_o   <= ofr_prio_d;
        offer_server_o <= ofr_srv_d;
      end
    end
  end
endmodule

// File: rtl/irq_source_ctrl_chk.sv
`timescale 1ns/1ps
module irq_source_ctrl_chk #(
  parameter int N      = 16,
  parameter int GNUM_W = 16,
  parameter int BASE   = 4096
) (
  input logic              clk,
  input logic              rst_n,
  input logic              offer_valid_o,
  input logic [GNUM_W-1:0] offer_num_o,
  input logic [7:0]        offer_prio_o,
  input logic [N-1:0]      req_vec,
  input logic [N-1:0]      gnt_vec
);
  localparam logic [GNUM_W:0] LO = (GNUM_W+1)'(BASE);
  localparam logic [GNUM_W:0] HI = (GNUM_W+1)'(BASE + N - 1);

  // R11
  offer_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid_o |-> ({1'b0, offer_num_o} >= LO && {1'b0, offer_num_o} <= HI));

  // R9
  offer_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid_o |-> (offer_prio_o != 8'hFF));

  // R9
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_vec));

  // R9
  grant_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt_vec) |-> (|(gnt_vec & req_vec)));

  // R1
  offer_follows_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid_o |-> $past(|req_vec));
endmodule

bind irq_source_ctrl irq_source_ctrl_chk #(.N(N), .GNUM_W(GNUM_W), .BASE(BASE)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .offer_valid_o (offer_valid_o),
  .offer_num_o   (offer_num_o),
  .offer_prio_o  (offer_prio_o),
  .req_vec       (req_vec),
  .gnt_vec       (gnt_vec)
);

// File: tb/test_irq_source_ctrl.sv
`timescale 1ns/1ps
module test_irq_source_ctrl;
  localparam int N    = 16;
  localparam int GW   = 16;
  localparam int BASE = 4096;
  localparam int SW   = 8;
  localparam int IW   = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  src_level, irq_line;
  logic          cfg_we;
  logic [IW-1:0] cfg_idx;
  logic [SW-1:0] cfg_server;
  logic [7:0]    cfg_prio;
  logic          rej_valid, eoi_valid, resend;
  logic [GW-1:0] rej_num, eoi_num;
  logic          offer_valid;
  logic [GW-1:0] offer_num;
  logic [7:0]    offer_prio;
  logic [SW-1:0] offer_server;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;  // 250 MHz

  irq_source_ctrl #(.N(N), .GNUM_W(GW), .BASE(BASE), .SRV_W(SW)) i_irq_source_ctrl (
    .clk (clk), .rst_n (rst_n), .src_level_i (src_level), .irq_line_i (irq_line),
    .cfg_we_i (cfg_we), .cfg_idx_i (cfg_idx), .cfg_server_i (cfg_server), .cfg_prio_i (cfg_prio),
    .rej_valid_i (rej_valid), .rej_num_i (rej_num), .eoi_valid_i (eoi_valid), .eoi_num_i (eoi_num),
    .resend_i (resend), .offer_valid_o (offer_valid), .offer_num_o (offer_num),
    .offer_prio_o (offer_prio), .offer_server_o (offer_server)
  );

  function automatic logic [GW-1:0] gnum(input int idx);
    return GW'(BASE + idx);
  endfunction

  task automatic step();
    @(negedge clk);
    cfg_we = 0; rej_valid = 0; eoi_valid = 0; resend = 0;
  endtask

  task automatic chk_offer(input string rq, input logic ev, input int eidx,
                           input logic [7:0] ep, input logic [SW-1:0] es);
    logic ok;
    n_chk++;
    if (ev) ok = offer_valid && offer_num == gnum(eidx) && offer_prio == ep && offer_server == es;
    else    ok = !offer_valid;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual v=%0b num=%0h prio=%0h srv=%0h expected v=%0b num=%0h prio=%0h srv=%0h",
               rq, offer_valid, offer_num, offer_prio, offer_server, ev, gnum(eidx), ep, es);
    end
  endtask

  task automatic cfg(input int idx, input int srv, input int prio);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_server = SW'(srv); cfg_prio = 8'(prio);
    step();
  endtask

  task automatic rej(input int num);
    rej_valid = 1; rej_num = GW'(num); step();
  endtask

  task automatic eoi(input int num);
    eoi_valid = 1; eoi_num = GW'(num); step();
  endtask

  task automatic rsnd();
    resend = 1; step();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] cfgp [8];
    bit         edged [8];
    bit         seen  [8];
    logic [7:0] prev_l, new_l;
    logic [GW-1:0] first;

    void'($urandom(32'd4242));
    src_level = 16'hFF00;  // sources 8..15 level, 0..7 message
    irq_line = '0; cfg_we = 0; cfg_idx = '0; cfg_server = '0; cfg_prio = '0;
    rej_valid = 0; rej_num = '0; eoi_valid = 0; eoi_num = '0; resend = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    step();
    chk_offer("R1 reset", 0, 0, 0, 0);

    // masked after reset: message edge only records pending
    irq_line[0] = 1; step(); irq_line[0] = 0; step();
    chk_offer("R1 masked after reset", 0, 0, 0, 0);
    cfg(0, 1, 5); step();
    chk_offer("R7 pending released by write", 1, 0, 8'h05, 1);
    step();
    chk_offer("R9 single-cycle offer", 0, 0, 0, 0);

    cfg(1, 2, 3); step();
    chk_offer("R7 write without pending", 0, 0, 0, 0);
    irq_line[1] = 1; step(); irq_line[1] = 0; step();
    chk_offer("R2 message edge", 1, 1, 8'h03, 2);

    rej(BASE + 1); step();
    chk_offer("R4 message reject silent", 0, 0, 0, 0);
    rsnd(); step();
    chk_offer("R5 message resend", 1, 1, 8'h03, 2);
    rsnd(); step();
    chk_offer("R5 second resend empty", 0, 0, 0, 0);
    eoi(BASE + 1); rsnd(); step();
    chk_offer("R6 eoi ignored by message", 0, 0, 0, 0);

    cfg(8, 3, 4); step();
    chk_offer("R7 level low no offer", 0, 0, 0, 0);
    irq_line[8] = 1; step(); step();
    chk_offer("R3 level rise", 1, 8, 8'h04, 3);
    for (int k = 0; k < 3; k++) begin
      step();
      chk_offer("R3 held line sent", 0, 0, 0, 0);
    end
    eoi(BASE + 8); step();
    chk_offer("R6 eoi silent", 0, 0, 0, 0);
    rsnd(); step();
    chk_offer("R5 level resend", 1, 8, 8'h04, 3);
    rej(BASE + 8); step();
    chk_offer("R4 level reject silent", 0, 0, 0, 0);
    rsnd(); step();
    chk_offer("R4 level reoffer after reject", 1, 8, 8'h04, 3);

    rej(BASE + 16); rej(BASE - 8); eoi(BASE + 24); eoi(BASE - 16 + 8);
    rsnd(); step();
    chk_offer("R8 out-of-range ignored", 0, 0, 0, 0);

    irq_line[8] = 0; step(); eoi(BASE + 8); rsnd(); step();
    chk_offer("R3 low line no offer", 0, 0, 0, 0);

    cfg(9, 5, 6);
    irq_line[9] = 1; step(); step();
    chk_offer("R3 second level source", 1, 9, 8'h06, 5);
    irq_line[9] = 0; step(); step();
    chk_offer("R3 fall no offer", 0, 0, 0, 0);
    rej_valid = 1; rej_num = gnum(9); irq_line[9] = 1; step(); step();
    chk_offer("R10 reject before line", 1, 9, 8'h06, 5);

    irq_line[10] = 1; step(); step();
    chk_offer("R1 masked level", 0, 0, 0, 0);
    cfg(10, 4, 7); step();
    chk_offer("R7 level write", 1, 10, 8'h07, 4);

    cfg(2, 0, 2); cfg(3, 0, 2);
    irq_line[2] = 1; irq_line[3] = 1; step();
    irq_line[2] = 0; irq_line[3] = 0; step();
    n_chk++;
    first = offer_num;
    if (!(offer_valid && (offer_num == gnum(2) || offer_num == gnum(3)))) begin
      n_fail++;
      $display("FAIL R9 first of pair: actual v=%0b num=%0h expected v=1 num=%0h or %0h",
               offer_valid, offer_num, gnum(2), gnum(3));
    end
    step();
    n_chk++;
    if (!(offer_valid && (offer_num == gnum(2) || offer_num == gnum(3)) && offer_num != first)) begin
      n_fail++;
      $display("FAIL R9 second of pair: actual v=%0b num=%0h expected v=1 num!=%0h",
               offer_valid, offer_num, first);
    end
    step();
    chk_offer("R9 pair drained", 0, 0, 0, 0);

    irq_line[9] = 0; irq_line[10] = 0;
    repeat (4) step();

    // random message traffic
    for (int i = 0; i < 8; i++) begin
      cfgp[i] = 8'($urandom % 255);
      edged[i] = 0; seen[i] = 0;
      cfg(i, i, cfgp[i]);
    end
    repeat (3) step();
    prev_l = '0;
    for (int c = 0; c < 440; c++) begin
      if (offer_valid) begin
        int idx;
        idx = int'(offer_num) - BASE;
        n_chk++;
        if (!(idx >= 0 && idx < 8 && offer_prio == cfgp[idx] && offer_server == SW'(idx))) begin
          n_fail++;
          $display("FAIL R11 random offer: actual num=%0h prio=%0h srv=%0h expected a message source with its configuration",
                   offer_num, offer_prio, offer_server);
        end else begin
          seen[idx] = 1;
        end
      end
      new_l = (c < 400) ? 8'($urandom) : 8'h00;
      for (int i = 0; i < 8; i++)
        if (new_l[i] && !prev_l[i]) edged[i] = 1;
      irq_line[7:0] = new_l;
      prev_l = new_l;
      step();
    end
    for (int i = 0; i < 8; i++) begin
      n_chk++;
      if (edged[i] && !seen[i]) begin
        n_fail++;
        $display("FAIL R2 random source %0d: actual offered=0 expected offered=1", i);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule